// File: doc/BRIEF.md
# Interrupt Routing Table Register File

This block holds the software-visible configuration of a 24-pin interrupt routing controller. Software reaches it through a select/window register pair. It writes a register number into the select register at offset 0x00. It then reads or writes that register through the 32-bit data window at offset 0x10. Behind the window are an identification register, a read-only version register and one 64-bit routing entry per pin. Each entry is split over two consecutive select values.

Every entry carries a vector, a delivery mode, a destination mode, a trigger mode, a polarity, a mask, a destination and two status bits owned by the hardware: delivery status and remote-IRR. Software writes cannot change these two status bits. The delivery logic next to this block sets and clears them through dedicated inputs. That logic reads the whole table from a flat output. It also receives two one-cycle event pulses: one when a pin's mask bit flips, and one when an entry that ends up level-triggered has just been rewritten.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x00 stores the low 8 bits of the data as the select value. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: A read of any offset other than 0x00 and 0x10 returns zero. A write to such an offset changes no state.
- R3: Select value 0x01 reads as the pin count minus one in bits 23:16 and the version code 0x11 in bits 7:0, giving 0x00170011 for 24 pins. Writes to it are ignored.
- R4: Select values 0x00 and 0x02 both read the 4-bit ID in bits 27:24, with all other bits zero. A window write with select 0x00 loads the ID from data bits 27:24. A window write with select 0x02 is ignored.
- R5: For a select value s of 0x10 or more, the entry index is (s − 0x10) >> 1. An even s maps to entry bits 31:0 and an odd s maps to bits 63:32. Entry i also appears on `tbl_flat[64*i+63 : 64*i]`. Apart from the status bits, every bit reads back as written, reserved bits included. Field positions: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote-IRR 14, trigger mode 15 (1 = level), mask 16, destination 63:56.
- R6: A window access whose computed index is 24 or more reads as 0xFFFFFFFF. This includes select values 0x03 to 0x0F, whose index wraps. A write to such an index changes no entry and raises no event.
- R7: A window write keeps the entry's remote-IRR bit (14) and delivery-status bit (12), whatever the data holds in those positions.
- R8: If the entry's trigger bit is 0 (edge) after a window write, its remote-IRR bit is 0.
- R9: A low-word write that flips a pin's mask bit pulses `mask_chg_valid` for exactly one cycle, in the cycle after the write. The pulse comes with `mask_chg_pin` set to the pin index and `mask_chg_val` set to the new mask. A write that leaves the mask unchanged raises no pulse.
- R10: A window write to an in-range entry whose trigger bit is 1 afterwards pulses `lvl_rw_valid` for one cycle, in the cycle after the write, with `lvl_rw_pin` set to the index. An edge result raises no pulse.
- R11: A read strobe produces `bus_rvalid` and `bus_rdata` exactly one cycle later. `bus_rvalid` is low in every other cycle.
- R12: After reset the select value is 0, the ID is 0, and every entry equals 0x0000000000010000, meaning only the mask bit is set.
- R13: When its entry is not being written, `hw_rirr_set[i]` sets remote-IRR of entry i on the next cycle and `hw_rirr_clr[i]` clears it, with set taking priority. The delivery-status bit of entry i follows `hw_busy[i]` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| hw_rirr_set | input | 24 | Per-pin remote-IRR set request |
| hw_rirr_clr | input | 24 | Per-pin remote-IRR clear request |
| hw_busy | input | 24 | Per-pin delivery-in-progress state |
| tbl_flat | output | 1536 | All entries, entry i at bits 64*i+63:64*i |
| mask_chg_valid | output | 1 | Mask flipped on a pin |
| mask_chg_pin | output | 5 | Pin whose mask flipped |
| mask_chg_val | output | 1 | New mask value |
| lvl_rw_valid | output | 1 | A level-triggered entry was rewritten |
| lvl_rw_pin | output | 5 | Pin of the rewritten level entry |

## Verification
On every cycle the assertions check the following. The status bits survive window writes. Remote-IRR is clear after an edge-result write. The mask bit moves only under a low-word write. The mask event agrees with the stored mask of the pin it names. The level event names an entry that is level-triggered. Read-valid follows a read strobe, and delivery status tracks the busy input. The bench scenarios cover the rest: the decoding of select values and offsets, the version and ID contents, the all-ones result of out-of-range indices, the read-back of reserved bits, and the absence of events and side effects on ignored writes.

// File: rtl/irq_route_pkg.sv
// Shared constants for the interrupt routing register file.
// Assumes 64-bit entries split into two 32-bit window words.
package irq_route_pkg;
    localparam int ENT_W     = 64;
    localparam int WORD_W    = 32;
    localparam int B_DSTAT   = 12;
    localparam int B_RIRR    = 14;
    localparam int B_TRIG    = 15;
    localparam int B_MASK    = 16;
    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL0 = 8'h10;
    localparam logic [ENT_W-1:0] ENT_RST = 64'h0000_0000_0001_0000;
endpackage

// File: rtl/irq_route_entry.sv
// One routing entry. It merges software word writes and keeps the
// hardware-owned status bits. Assumes at most one word is written per cycle.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rirr_set,
    input  logic              rirr_clr,
    input  logic              busy,
    output logic [ENT_W-1:0]  ent_q,
    output logic              mask_flip,
    output logic              lvl_wr
);
    logic [ENT_W-1:0] ent_d;
    logic             any_wr;

    assign any_wr = wr_lo | wr_hi;

    // Build the next entry: software words first, then the status bits on top.
    always_comb begin
        ent_d = ent_q;
        if (wr_lo) ent_d[WORD_W-1:0]     = wdata;
        if (wr_hi) ent_d[ENT_W-1:WORD_W] = wdata;
        ent_d[B_DSTAT] = busy;
        if (any_wr)
            ent_d[B_RIRR] = ent_d[B_TRIG] ? ent_q[B_RIRR] : 1'b0;
        else if (rirr_set)
            ent_d[B_RIRR] = 1'b1;
        else if (rirr_clr)
            ent_d[B_RIRR] = 1'b0;
        else
            ent_d[B_RIRR] = ent_q[B_RIRR];
    end

    // Entry storage; reset leaves only the mask bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= ENT_RST;
        else        ent_q <= ent_d;
    end

    assign mask_flip = wr_lo & (wdata[B_MASK] != ent_q[B_MASK]);
    assign lvl_wr    = any_wr & ent_d[B_TRIG];

    assert_rirr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && ent_d[B_TRIG]) |=> ent_q[B_RIRR] == $past(ent_q[B_RIRR]));
    assert_edge_rirr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && !ent_d[B_TRIG]) |=> !ent_q[B_RIRR]);
    assert_mask_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(ent_q[B_MASK]));
    assert_dstat_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ent_q[B_DSTAT] == $past(busy));
endmodule

// File: rtl/irq_route_rdmux.sv
// Combinational read path. It decodes the offset and the select value
// into one 32-bit word. Assumes the table arrives flattened, entry i at 64*i.
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VER_CODE = 8'h11,
    parameter int         IDX_W    = 7
)(
    input  logic [7:0]             addr,
    input  logic [7:0]             sel,
    input  logic [3:0]             id,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   idx_ok,
    input  logic [NPINS*ENT_W-1:0] tbl,
    output logic [WORD_W-1:0]      rd_word
);
    localparam logic [7:0] TOP_PIN = 8'(NPINS - 1);

    logic [WORD_W-1:0] win_word;
    logic [ENT_W-1:0]  ent_sel;

    // Pick the addressed entry; an out-of-range index yields zero here.
    always_comb begin
        ent_sel = '0;
        for (int p = 0; p < NPINS; p++)
            if (idx_ok && idx == IDX_W'(p)) ent_sel = tbl[p*ENT_W +: ENT_W];
    end

    // Decode what the data window shows for the current select value.
    always_comb begin
        case (sel)
            SEL_VER:         win_word = {8'h00, TOP_PIN, 8'h00, VER_CODE};
            SEL_ID, SEL_ARB: win_word = {4'h0, id, 24'h000000};
            default: begin
                if (!idx_ok)     win_word = '1;
                else if (sel[0]) win_word = ent_sel[ENT_W-1:WORD_W];
                else             win_word = ent_sel[WORD_W-1:0];
            end
        endcase
    end

    // Offset decode: select register, data window, or zero.
    always_comb begin
        case (addr)
            OFS_SEL: rd_word = {24'h000000, sel};
            OFS_WIN: rd_word = win_word;
            default: rd_word = '0;
        endcase
    end
endmodule

// File: rtl/irq_route_regs.sv
// Top of the routing register file: select/window decode, ID register,
// the per-pin entries and the event pulses for the delivery logic.
// Assumes single-cycle write and read strobes and a synchronous active-low reset.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VER_CODE = 8'h11,
    localparam int        PIN_W    = $clog2(NPINS),
    localparam int        IDX_W    = 7
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NPINS-1:0]       hw_rirr_set,
    input  logic [NPINS-1:0]       hw_rirr_clr,
    input  logic [NPINS-1:0]       hw_busy,
    output logic [NPINS*64-1:0]    tbl_flat,
    output logic                   mask_chg_valid,
    output logic [PIN_W-1:0]       mask_chg_pin,
    output logic                   mask_chg_val,
    output logic                   lvl_rw_valid,
    output logic [PIN_W-1:0]       lvl_rw_pin
);
    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [7:0]       sel_off;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic             win_wr;
    logic [NPINS-1:0] flip_v;
    logic [NPINS-1:0] lvl_v;
    logic [31:0]      rd_word;

    assign sel_off = sel_q - SEL_TBL0;
    assign idx     = sel_off[7:1];
    assign idx_ok  = (sel_q >= SEL_TBL0) && (idx < IDX_W'(NPINS));
    assign win_wr  = bus_wr && (bus_addr == OFS_WIN);

    // Select register and ID register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (bus_wr && bus_addr == OFS_SEL) begin
            sel_q <= bus_wdata[7:0];
        end else if (win_wr && sel_q == SEL_ID) begin
            id_q <= bus_wdata[27:24];
        end
    end

    // One entry per pin, write-enabled by the decoded index and word half.
    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic hit;
        assign hit = win_wr && idx_ok && (idx == IDX_W'(g));
        irq_route_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && !sel_q[0]),
            .wr_hi    (hit && sel_q[0]),
            .wdata    (bus_wdata),
            .rirr_set (hw_rirr_set[g]),
            .rirr_clr (hw_rirr_clr[g]),
            .busy     (hw_busy[g]),
            .ent_q    (tbl_flat[g*ENT_W +: ENT_W]),
            .mask_flip(flip_v[g]),
            .lvl_wr   (lvl_v[g])
        );
    end

    irq_route_rdmux #(.NPINS(NPINS), .VER_CODE(VER_CODE), .IDX_W(IDX_W)) u_rd (
        .addr   (bus_addr),
        .sel    (sel_q),
        .id     (id_q),
        .idx    (idx),
        .idx_ok (idx_ok),
        .tbl    (tbl_flat),
        .rd_word(rd_word)
    );

    // Register read data with its valid strobe (one-cycle latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_word;
        end
    end

    // Event pulses for the delivery logic, one cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_val   <= 1'b0;
            lvl_rw_valid   <= 1'b0;
            lvl_rw_pin     <= '0;
        end else begin
            mask_chg_valid <= |flip_v;
            lvl_rw_valid   <= |lvl_v;
            if (|flip_v) begin
                mask_chg_pin <= idx[PIN_W-1:0];
                mask_chg_val <= bus_wdata[B_MASK];
            end
            if (|lvl_v) lvl_rw_pin <= idx[PIN_W-1:0];
        end
    end

    assert_rvalid_follows_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));
    assert_mask_evt_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> tbl_flat[mask_chg_pin*ENT_W + B_MASK] == mask_chg_val);
    assert_mask_evt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |=> !mask_chg_valid || $past(|flip_v));
    assert_lvl_evt_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_rw_valid |-> tbl_flat[lvl_rw_pin*ENT_W + B_TRIG]);
endmodule

// File: tb/irq_route_regs_test.sv
`timescale 1ns/1ps
module irq_route_regs_test;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] hw_rirr_set = '0, hw_rirr_clr = '0, hw_busy = '0;
    logic [NP*64-1:0] tbl_flat;
    logic          mask_chg_valid, mask_chg_val, lvl_rw_valid;
    logic [4:0]    mask_chg_pin, lvl_rw_pin;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic       ev_mask, ev_mval, ev_lvl;
    logic [4:0] ev_mpin, ev_lpin;
    logic [31:0] rd_val;
    logic        rd_ok;

    always #10 clk = ~clk;

    irq_route_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .hw_rirr_set(hw_rirr_set),
        .hw_rirr_clr(hw_rirr_clr), .hw_busy(hw_busy), .tbl_flat(tbl_flat),
        .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin),
        .mask_chg_val(mask_chg_val), .lvl_rw_valid(lvl_rw_valid),
        .lvl_rw_pin(lvl_rw_pin)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Write one word; captures the event outputs one cycle later.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        ev_mask = mask_chg_valid; ev_mpin = mask_chg_pin; ev_mval = mask_chg_val;
        ev_lvl = lvl_rw_valid; ev_lpin = lvl_rw_pin;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_val = bus_rdata; rd_ok = bus_rvalid;
    endtask

    task automatic rd_win(input logic [7:0] s);
        wr(8'h00, {24'h0, s});
        rd(8'h10);
    endtask

    task automatic t_reset;
        bit ok = 1;
        for (int i = 0; i < NP; i++)
            if (tbl_flat[i*64 +: 64] !== 64'h10000) ok = 0;
        chk("R12 all entries masked", {63'b0, ok}, 64'd1);
        chk("R11 rvalid idle", {63'b0, bus_rvalid}, 64'd0);
        rd(8'h00);
        chk("R12 select zero", {32'b0, rd_val}, 64'd0);
        rd(8'h10);
        chk("R12 id zero", {32'b0, rd_val}, 64'd0);
    endtask

    task automatic t_select;
        wr(8'h00, 32'h123456A5);
        rd(8'h00);
        chk("R1 select low byte", {32'b0, rd_val}, 64'hA5);
        chk("R11 rvalid with data", {63'b0, rd_ok}, 64'd1);
        @(negedge clk);
        chk("R11 rvalid one cycle", {63'b0, bus_rvalid}, 64'd0);
    endtask

    task automatic t_other;
        logic [NP*64-1:0] snap;
        wr(8'h00, 32'h10);
        snap = tbl_flat;
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h20);
        chk("R2 other offset reads zero", {32'b0, rd_val}, 64'd0);
        rd(8'h04);
        chk("R2 offset 04 reads zero", {32'b0, rd_val}, 64'd0);
        rd(8'h00);
        chk("R2 select untouched", {32'b0, rd_val}, 64'h10);
        chk("R2 table untouched", {63'b0, tbl_flat == snap}, 64'd1);
    endtask

    task automatic t_version;
        rd_win(8'h01);
        chk("R3 version", {32'b0, rd_val}, 64'h00170011);
        wr(8'h10, 32'h0);
        rd(8'h10);
        chk("R3 version after write", {32'b0, rd_val}, 64'h00170011);
    endtask

    task automatic t_id;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hFA00FFFF);
        rd(8'h10);
        chk("R4 id write", {32'b0, rd_val}, 64'h0A000000);
        rd_win(8'h02);
        chk("R4 arb alias", {32'b0, rd_val}, 64'h0A000000);
        wr(8'h10, 32'h05000000);
        rd_win(8'h00);
        chk("R4 arb write ignored", {32'b0, rd_val}, 64'h0A000000);
    endtask

    task automatic t_entry;
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0000A135);
        chk("R9 mask event", {61'b0, ev_mask, ev_mval, 1'b0}, {61'b0, 1'b1, 1'b0, 1'b0});
        chk("R9 mask pin", {59'b0, ev_mpin}, 64'd5);
        chk("R10 level event", {58'b0, ev_lvl, ev_lpin}, {58'b0, 1'b1, 5'd5});
        rd(8'h10);
        chk("R5 low word", {32'b0, rd_val}, 64'h0000A135);
        wr(8'h00, 32'h1B);
        wr(8'h10, 32'hC300007E);
        chk("R9 hi write no mask event", {63'b0, ev_mask}, 64'd0);
        rd(8'h10);
        chk("R5 high word reserved bits", {32'b0, rd_val}, 64'hC300007E);
        chk("R5 flat entry", tbl_flat[5*64 +: 64], 64'hC300007E_0000A135);
        chk("R5 neighbour", tbl_flat[4*64 +: 64], 64'h10000);
    endtask

    task automatic t_range;
        logic [NP*64-1:0] snap;
        rd_win(8'h40);
        chk("R6 index 24 ones", {32'b0, rd_val}, 64'hFFFFFFFF);
        snap = tbl_flat;
        wr(8'h10, 32'h00000000);
        chk("R6 no event", {62'b0, ev_mask, ev_lvl}, 64'd0);
        chk("R6 write dropped", {63'b0, tbl_flat == snap}, 64'd1);
        rd_win(8'h05);
        chk("R6 wrapped select ones", {32'b0, rd_val}, 64'hFFFFFFFF);
        rd_win(8'h3F);
        chk("R5 last pin high", {32'b0, rd_val}, 64'h0);
    endtask

    task automatic t_status;
        @(negedge clk); hw_rirr_set[5] = 1'b1;
        @(negedge clk); hw_rirr_set[5] = 1'b0;
        rd_win(8'h1A);
        chk("R13 rirr set", {32'b0, rd_val}, 64'h0000E135);
        wr(8'h10, 32'h00018042);
        chk("R9 mask set event", {58'b0, ev_mask, ev_mval, 4'b0} | {59'b0, ev_mpin},
            {58'b0, 2'b11, 4'b0} | 64'd5);
        rd(8'h10);
        chk("R7 rirr kept", {32'b0, rd_val}, 64'h0001C042);
        @(negedge clk); hw_busy[5] = 1'b1;
        @(negedge clk);
        wr(8'h10, 32'h00018042);
        chk("R9 unchanged mask no event", {63'b0, ev_mask}, 64'd0);
        rd(8'h10);
        chk("R7 dstat kept", {32'b0, rd_val}, 64'h0001D042);
        wr(8'h10, 32'h00014042);
        chk("R10 edge no level event", {63'b0, ev_lvl}, 64'd0);
        rd(8'h10);
        chk("R8 edge clears rirr", {32'b0, rd_val}, 64'h00011042);
        @(negedge clk); hw_busy[5] = 1'b0; hw_rirr_set[5] = 1'b1;
        @(negedge clk); hw_rirr_set[5] = 1'b0; hw_rirr_clr[5] = 1'b1;
        chk("R13 set then", {63'b0, tbl_flat[5*64+14]}, 64'd1);
        @(negedge clk); hw_rirr_clr[5] = 1'b0;
        chk("R13 clear", {62'b0, tbl_flat[5*64+14], tbl_flat[5*64+12]}, 64'd0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_other();
        t_version();
        t_id();
        t_entry();
        t_range();
        t_status();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule